// File: doc/BRIEF.md
# Ones and Transition Count Compactor

This block condenses the serial response of a single-output circuit under test into a short count signature during a built-in self-test session. A session opens with a one-cycle start pulse. After that, each cycle that carries a valid strobe delivers one response bit. Two signatures are built side by side. The first is the number of accepted bits equal to 1. The second is the number of accepted bits that differ from the accepted bit before them.

When the stream ends, a one-cycle done pulse judges the session. The mode input picks which signature is used, and that signature is compared with a golden value supplied on a port. The verdict appears as a pass flag and a fail flag, qualified by a result-valid flag. The verdict stays in place until the next start pulse.

Both counters are as wide as a stream of the configured maximum length needs. They stop at their largest value and never wrap.

Top module: `resp_count_compactor`

## Requirements
- R1: While reset is high, and in the first cycle after it, both counts read 0 and result-valid, pass and fail are all low.
- R2: The ones count goes up by one on each clock edge where valid is high and the response bit is 1. A bit offered with valid low changes neither count.
- R3: The transition count goes up by one when an accepted bit differs from the previously accepted bit. The first bit accepted after reset or start never counts as a transition.
- R4: The stream 1,0,0,0,0,0,0,0 gives a ones count of 1 and a transition count of 1. The stream 1,1,0,0,0,0,0,0 gives 2 and 1. Eight zeros give 0 and 0.
- R5: Each count stops at 2^CW-1, where CW = ceil(log2(MAX_LEN+1)), and does not wrap.
- R6: A start pulse clears both counts, the stored previous bit and the verdict. A valid bit or a done pulse arriving in the same cycle as start is dropped.
- R7: Done judges a selected signature. Mode 0 selects the ones count and mode 1 selects the transition count. From the next cycle on, result-valid is 1, pass is 1 exactly when the selected count equals the golden value, and fail is its complement. The verdict holds until the next start or the next done.
- R8: A bit accepted in the same cycle as done is included in the count that done judges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Opens a session and clears all state |
| valid_i | input | 1 | Response bit strobe |
| bit_i | input | 1 | Response bit |
| done_i | input | 1 | Closes the session and judges the signature |
| mode_i | input | 1 | 0 selects the ones count, 1 selects the transition count |
| golden_i | input | CW | Expected signature |
| ones_o | output | CW | Ones count |
| trans_o | output | CW | Transition count |
| result_valid_o | output | 1 | Verdict present |
| pass_o | output | 1 | Signature matched the golden value |
| fail_o | output | 1 | Signature did not match the golden value |

## Verification
Two pairs of events can share a clock edge. The first pair is done with a valid bit. The bench raises done in the same cycle as the last bit of a stream, and the golden value only matches if that bit is counted. The second pair is start with a valid bit and a done pulse. The bench expects both counts to read zero and no verdict, and a behavioural model compares counts and verdict after every edge.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

    typedef enum logic {
        SIG_ONES  = 1'b0,
        SIG_TRANS = 1'b1
    } sig_sel_e;

    typedef struct packed {
        logic valid;
        logic pass;
        logic fail;
    } verdict_t;

    function automatic int unsigned cnt_width(input int unsigned max_len);
        return $clog2(max_len + 1);
    endfunction

endpackage

// File: rtl/rcc_sat_counter.sv
module rcc_sat_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] cnt_nxt_o
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] cnt_q;

    always_comb begin
        if (clr)
            cnt_nxt_o = '0;
        else if (inc && (cnt_q != TOP))
            cnt_nxt_o = cnt_q + 1'b1;
        else
            cnt_nxt_o = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_nxt_o;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/rcc_toggle_detect.sv
module rcc_toggle_detect (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic take,
    input  logic bit_in,
    output logic toggle_o
);
    logic prev_q;
    logic seen_q;

    assign toggle_o = take && seen_q && (bit_in != prev_q);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            prev_q <= 1'b0;
            seen_q <= 1'b0;
        end else if (take) begin
            prev_q <= bit_in;
            seen_q <= 1'b1;
        end
    end
endmodule

// File: rtl/rcc_verdict.sv
module rcc_verdict
    import rcc_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         judge,
    input  sig_sel_e     sel,
    input  logic [W-1:0] ones_nxt,
    input  logic [W-1:0] trans_nxt,
    input  logic [W-1:0] golden,
    output verdict_t     verdict_o
);
    logic [W-1:0] chosen;
    logic         match;

    always_comb begin
        case (sel)
            SIG_TRANS: chosen = trans_nxt;
            default:   chosen = ones_nxt;
        endcase
        match = (chosen == golden);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            verdict_o <= '0;
        end else if (judge) begin
            verdict_o.valid <= 1'b1;
            verdict_o.pass  <= match;
            verdict_o.fail  <= !match;
        end
    end
endmodule

// File: rtl/resp_count_compactor.sv
module resp_count_compactor
    import rcc_pkg::*;
#(
    parameter int unsigned MAX_LEN = 255,
    localparam int unsigned CW = cnt_width(MAX_LEN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          valid_i,
    input  logic          bit_i,
    input  logic          done_i,
    input  logic          mode_i,
    input  logic [CW-1:0] golden_i,
    output logic [CW-1:0] ones_o,
    output logic [CW-1:0] trans_o,
    output logic          result_valid_o,
    output logic          pass_o,
    output logic          fail_o
);
    logic          take;
    logic          toggle;
    logic [CW-1:0] ones_nxt;
    logic [CW-1:0] trans_nxt;
    verdict_t      verdict;
    sig_sel_e      sel;

    assign take = valid_i && !start_i;
    assign sel  = sig_sel_e'(mode_i);

    rcc_sat_counter #(.W(CW)) u_ones (
        .clk(clk), .rst(rst), .clr(start_i), .inc(take && bit_i),
        .cnt_o(ones_o), .cnt_nxt_o(ones_nxt)
    );

    rcc_toggle_detect u_tog (
        .clk(clk), .rst(rst), .clr(start_i), .take(take),
        .bit_in(bit_i), .toggle_o(toggle)
    );

    rcc_sat_counter #(.W(CW)) u_trans (
        .clk(clk), .rst(rst), .clr(start_i), .inc(toggle),
        .cnt_o(trans_o), .cnt_nxt_o(trans_nxt)
    );

    rcc_verdict #(.W(CW)) u_judge (
        .clk(clk), .rst(rst), .clr(start_i), .judge(done_i && !start_i),
        .sel(sel), .ones_nxt(ones_nxt), .trans_nxt(trans_nxt),
        .golden(golden_i), .verdict_o(verdict)
    );

    assign result_valid_o = verdict.valid;
    assign pass_o         = verdict.pass;
    assign fail_o         = verdict.fail;
endmodule

// File: rtl/resp_count_compactor_chk.sv
module resp_count_compactor_chk #(
    parameter int unsigned CW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          start_i,
    input logic          valid_i,
    input logic          bit_i,
    input logic          done_i,
    input logic [CW-1:0] ones_o,
    input logic [CW-1:0] trans_o,
    input logic          result_valid_o,
    input logic          pass_o,
    input logic          fail_o
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (ones_o == '0 && trans_o == '0 && !result_valid_o && !pass_o && !fail_o));

    a_r7_verdict_onehot: assert property (@(posedge clk) disable iff (rst)
        result_valid_o |-> (pass_o ^ fail_o));

    a_r7_no_verdict_flags: assert property (@(posedge clk) disable iff (rst)
        !result_valid_o |-> (!pass_o && !fail_o));

    a_r6_start_clears: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (ones_o == '0 && trans_o == '0 && !result_valid_o));

    a_r2_ones_idle: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !(valid_i && bit_i)) |=> $stable(ones_o));

    a_r3_trans_idle: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !valid_i) |=> $stable(trans_o));

    a_r5_no_wrap: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> (ones_o >= $past(ones_o) && trans_o >= $past(trans_o)));

    a_r7_verdict_hold: assert property (@(posedge clk) disable iff (rst)
        (result_valid_o && !start_i && !done_i) |=> ($stable(pass_o) && result_valid_o));
endmodule

bind resp_count_compactor resp_count_compactor_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst(rst), .start_i(start_i), .valid_i(valid_i), .bit_i(bit_i),
    .done_i(done_i), .ones_o(ones_o), .trans_o(trans_o),
    .result_valid_o(result_valid_o), .pass_o(pass_o), .fail_o(fail_o)
);

// File: tb/resp_count_compactor_tb.sv
module resp_count_compactor_tb_top;
    localparam int unsigned MAX_LEN = 255;
    localparam int unsigned CW = $clog2(MAX_LEN + 1);
    localparam int TOPV = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0, valid_i = 1'b0, bit_i = 1'b0, done_i = 1'b0, mode_i = 1'b0;
    logic [CW-1:0] golden_i = '0;
    logic [CW-1:0] ones_o, trans_o;
    logic result_valid_o, pass_o, fail_o;

    always #10 clk = ~clk;

    resp_count_compactor #(.MAX_LEN(MAX_LEN)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .valid_i(valid_i), .bit_i(bit_i),
        .done_i(done_i), .mode_i(mode_i), .golden_i(golden_i),
        .ones_o(ones_o), .trans_o(trans_o), .result_valid_o(result_valid_o),
        .pass_o(pass_o), .fail_o(fail_o)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    int m_ones = 0, m_trans = 0, m_prev = 0, m_seen = 0, m_rv = 0, m_pass = 0, m_fail = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_update();
        int sel;
        if (rst || start_i) begin
            m_ones = 0; m_trans = 0; m_prev = 0; m_seen = 0;
            m_rv = 0; m_pass = 0; m_fail = 0;
        end else begin
            if (valid_i) begin
                if (bit_i && m_ones < TOPV) m_ones++;
                if (m_seen != 0 && int'(bit_i) != m_prev && m_trans < TOPV) m_trans++;
                m_prev = int'(bit_i);
                m_seen = 1;
            end
            if (done_i) begin
                sel = mode_i ? m_trans : m_ones;
                m_rv = 1;
                m_pass = (sel == int'(golden_i)) ? 1 : 0;
                m_fail = 1 - m_pass;
            end
        end
    endtask

    task automatic step(input logic s, input logic v, input logic b,
                        input logic d, input logic m, input int g);
        start_i = s; valid_i = v; bit_i = b; done_i = d; mode_i = m;
        golden_i = CW'(g);
        @(posedge clk);
        @(negedge clk);
        model_update();
        chk("R2 ones", int'(ones_o), m_ones);
        chk("R3 trans", int'(trans_o), m_trans);
        chk("R7 result_valid", int'(result_valid_o), m_rv);
        chk("R7 pass", int'(pass_o), m_pass);
        chk("R7 fail", int'(fail_o), m_fail);
    endtask

    task automatic feed(input logic [7:0] pat);
        for (int i = 7; i >= 0; i--) step(0, 1, pat[i], 0, 0, 0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=expired expected=done");
        summary();
    end

    initial begin
        @(negedge clk);
        step(0, 1, 1, 1, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        rst = 1'b0;
        step(0, 0, 0, 0, 0, 0);
        // R1: reset state at the ports
        chk("R1 ones", int'(ones_o), 0);
        chk("R1 trans", int'(trans_o), 0);
        chk("R1 result_valid", int'(result_valid_o), 0);

        // R4 stream 10000000, judged on ones count
        step(1, 0, 0, 0, 0, 0);
        feed(8'b1000_0000);
        chk("R4 ones 10000000", int'(ones_o), 1);
        chk("R4 trans 10000000", int'(trans_o), 1);
        step(0, 0, 0, 1, 0, 1);
        chk("R7 pass mode0", int'(pass_o), 1);

        // R4 stream 11000000, judged on transition count, then a mismatch
        step(1, 0, 0, 0, 0, 0);
        feed(8'b1100_0000);
        chk("R4 ones 11000000", int'(ones_o), 2);
        chk("R4 trans 11000000", int'(trans_o), 1);
        step(0, 0, 0, 1, 1, 1);
        chk("R7 pass mode1", int'(pass_o), 1);
        step(0, 0, 0, 0, 0, 0);
        chk("R7 verdict held", int'(pass_o), 1);
        step(0, 0, 0, 1, 1, 2);
        chk("R7 fail mode1", int'(fail_o), 1);

        // R4 all zeros
        step(1, 0, 0, 0, 0, 0);
        feed(8'b0000_0000);
        chk("R4 ones zeros", int'(ones_o), 0);
        chk("R4 trans zeros", int'(trans_o), 0);

        // R3: first bit after start never a transition
        step(1, 0, 0, 0, 0, 0);
        step(0, 1, 1, 0, 0, 0);
        chk("R3 first bit", int'(trans_o), 0);

        // R2: bits with valid low are dropped
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0);
        chk("R2 invalid ignored ones", int'(ones_o), 1);
        chk("R3 invalid ignored trans", int'(trans_o), 0);

        // R8: done together with a bit; golden matches only if the bit counts
        step(0, 1, 0, 0, 0, 0);
        step(0, 1, 1, 1, 1, 2);
        chk("R8 coincident pass", int'(pass_o), 1);
        chk("R8 trans", int'(trans_o), 2);

        // R6: start with a bit and done in the same cycle
        step(1, 1, 1, 1, 0, 0);
        chk("R6 ones cleared", int'(ones_o), 0);
        chk("R6 verdict cleared", int'(result_valid_o), 0);
        step(0, 1, 0, 0, 0, 0);
        chk("R6 prev cleared", int'(trans_o), 0);

        // Mixed stream with gaps
        step(1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 200; i++)
            step(0, ((i * 7) % 5) != 0, ((i * 13) % 7) > 2, 0, 0, 0);
        step(0, 0, 0, 1, 0, m_ones);
        chk("R7 mixed pass", int'(pass_o), 1);

        // R5: saturation of both counts
        step(1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 300; i++) step(0, 1, 1, 0, 0, 0);
        chk("R5 ones saturate", int'(ones_o), TOPV);
        step(1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 600; i++) step(0, 1, i[0], 0, 0, 0);
        chk("R5 trans saturate", int'(trans_o), TOPV);
        step(0, 0, 0, 1, 1, TOPV);
        chk("R5 saturated pass", int'(pass_o), 1);

        summary();
    end
endmodule